// File: doc/BRIEF.md
# Battery Backup Switchover and Memory Write-Protect Controller

This block is the digital decision logic that sits beside a battery-backed memory. Converters outside it deliver three unsigned millivolt codes (the main supply, the backup cell and an auxiliary monitored rail), and a strobe marks each new set of samples. The block also takes the active-low chip-enable request that address decoding produces for the memory.

From each sample set it decides four things. The first is whether the memory's supply rail should be fed from the main supply or from the battery. The second is whether the memory's chip enable may pass or must be blocked. The third is a power-fail indication for the rest of the system. The fourth is an early-warning flag for a low auxiliary rail.

The source decision has a dead band around the battery voltage, and the auxiliary detector has a small hysteresis. Slowly drifting rails therefore do not make the outputs chatter. While the system runs from the battery, the auxiliary detector is shut off.

Top module: `bkup_switch_ctl`

## Requirements
- R1: After a synchronous reset the source select is main (`on_batt`=0), `ce_out_n`=1, `pwr_fail_n`=0 and `thr_n`=1.
- R2: A sample set is captured at the clock edge where `smp_vld` is high, and the outputs update at the following edge. Without a strobe the outputs hold, whatever the sample inputs do.
- R3: While on main, the source moves to battery once main + 10 mV <= battery.
- R4: While on battery, the source moves back to main once main >= battery + 10 mV.
- R5: Inside the band between those two points, the source select keeps its previous value.
- R6: `pwr_fail_n` is 1 when main >= 4500 mV and 0 when main < 4500 mV.
- R7: `ce_out_n` equals the captured `ce_req_n` while `pwr_fail_n` is 1. While `pwr_fail_n` is 0, `ce_out_n` is forced to 1.
- R8: With the detector active, `thr_n` falls when aux < 1300 mV. It rises again only once aux >= 1310 mV, and it holds in between.
- R9: Whenever the source is battery, `thr_n` is 1 and the detector's low state is cleared. After a return to main, it falls again only when aux < 1300 mV.
- R10: All comparisons are made on widened unsigned values. Codes near full scale (8191 for 13 bits) never wrap into a false switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | New sample set present |
| main_mv | input | 13 | Main supply, millivolts |
| batt_mv | input | 13 | Backup battery, millivolts |
| aux_mv | input | 13 | Auxiliary monitored rail, millivolts |
| ce_req_n | input | 1 | Requested memory chip enable, active low |
| on_batt | output | 1 | 1 = memory rail fed from battery |
| ce_out_n | output | 1 | Gated memory chip enable, active low |
| pwr_fail_n | output | 1 | 0 = main supply below trip |
| thr_n | output | 1 | 0 = auxiliary rail below threshold |

## Verification
The assertions check the following on every cycle:
- outputs hold between updates;
- the chip enable stays blocked whenever power-fail is low;
- the auxiliary flag stays inactive while on battery;
- the source select holds inside its dead band;
- the reset state is correct.

Only the directed scenarios can show the exact trip codes: 10 mV on each side of the battery, 4500 for the supply trip and 1300/1310 for the auxiliary rail. The same holds for clearing the detector state across a battery excursion and for the absence of wrap-around at full-scale codes.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  typedef enum logic {SRC_MAIN = 1'b0, SRC_BATT = 1'b1} src_e;
endpackage

// File: rtl/bkup_sample_reg.sv
module bkup_sample_reg #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_vld,
  input  logic [W-1:0] main_mv,
  input  logic [W-1:0] batt_mv,
  input  logic [W-1:0] aux_mv,
  input  logic         ce_req_n,
  output logic [W-1:0] main_q,
  output logic [W-1:0] batt_q,
  output logic [W-1:0] aux_q,
  output logic         ce_q,
  output logic         upd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= '0;
      batt_q <= '0;
      aux_q  <= '0;
      ce_q   <= 1'b1;
      upd    <= 1'b0;
    end else begin
      upd <= smp_vld;
      if (smp_vld) begin
        main_q <= main_mv;
        batt_q <= batt_mv;
        aux_q  <= aux_mv;
        ce_q   <= ce_req_n;
      end
    end
  end
endmodule

// File: rtl/bkup_hyst_cmp.sv
module bkup_hyst_cmp #(
  parameter int W      = 13,
  parameter int LO_MV  = 1300,
  parameter int HI_MV  = 1310,
  parameter bit RST_LO = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic         clr,
  input  logic [W-1:0] x,
  output logic         low_st
);
  localparam int XW = W + 2;
  localparam logic [XW-1:0] LO_C = XW'(LO_MV);
  localparam logic [XW-1:0] HI_C = XW'(HI_MV);

  logic [XW-1:0] xx;
  logic          low_nxt;

  always_comb begin
    xx      = XW'(x);
    low_nxt = low_st;
    if (clr)                        low_nxt = 1'b0;
    else if (!low_st && xx < LO_C)  low_nxt = 1'b1;
    else if (low_st && xx >= HI_C)  low_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)      low_st <= RST_LO;
    else if (upd) low_st <= low_nxt;
  end

  // R8: inside the hysteresis band the state holds
  a_r8_band_hold: assert property (@(posedge clk) disable iff (rst)
    (upd && !clr && xx >= LO_C && xx < HI_C) |=> $stable(low_st));
endmodule

// File: rtl/bkup_supply_sel.sv
module bkup_supply_sel
  import bkup_pkg::*;
#(
  parameter int W     = 13,
  parameter int DN_MV = 10,
  parameter int UP_MV = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] main_q,
  input  logic [W-1:0] batt_q,
  output src_e         sel,
  output src_e         sel_nxt
);
  localparam int XW = W + 2;
  localparam logic [XW-1:0] DN_C = XW'(DN_MV);
  localparam logic [XW-1:0] UP_C = XW'(UP_MV);

  logic [XW-1:0] m, b;
  logic          go_batt, go_main;

  always_comb begin
    m       = XW'(main_q);
    b       = XW'(batt_q);
    go_batt = (m + DN_C) <= b;
    go_main = m >= (b + UP_C);
    sel_nxt = sel;
    if (sel == SRC_MAIN && go_batt)      sel_nxt = SRC_BATT;
    else if (sel == SRC_BATT && go_main) sel_nxt = SRC_MAIN;
  end

  always_ff @(posedge clk) begin
    if (rst)      sel <= SRC_MAIN;
    else if (upd) sel <= sel_nxt;
  end

  // R5: no switch from either side while inside the dead band
  a_r5_band_hold: assert property (@(posedge clk) disable iff (rst)
    (upd && (m + DN_C) > b && m < (b + UP_C)) |=> $stable(sel));
endmodule

// File: rtl/bkup_switch_ctl.sv
module bkup_switch_ctl
  import bkup_pkg::*;
#(
  parameter int W       = 13,
  parameter int SW_DN   = 10,
  parameter int SW_UP   = 10,
  parameter int TRIP_MV = 4500,
  parameter int AUX_LO  = 1300,
  parameter int AUX_HI  = 1310
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_vld,
  input  logic [W-1:0] main_mv,
  input  logic [W-1:0] batt_mv,
  input  logic [W-1:0] aux_mv,
  input  logic         ce_req_n,
  output logic         on_batt,
  output logic         ce_out_n,
  output logic         pwr_fail_n,
  output logic         thr_n
);
  logic [W-1:0] main_q, batt_q, aux_q;
  logic         ce_q, upd, ce_hold, pf_low, thr_low;
  src_e         sel, sel_nxt;

  bkup_sample_reg #(.W(W)) u_smp (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .main_mv(main_mv), .batt_mv(batt_mv), .aux_mv(aux_mv), .ce_req_n(ce_req_n),
    .main_q(main_q), .batt_q(batt_q), .aux_q(aux_q), .ce_q(ce_q), .upd(upd)
  );

  bkup_supply_sel #(.W(W), .DN_MV(SW_DN), .UP_MV(SW_UP)) u_sel (
    .clk(clk), .rst(rst), .upd(upd),
    .main_q(main_q), .batt_q(batt_q), .sel(sel), .sel_nxt(sel_nxt)
  );

  bkup_hyst_cmp #(.W(W), .LO_MV(TRIP_MV), .HI_MV(TRIP_MV), .RST_LO(1'b1)) u_pf (
    .clk(clk), .rst(rst), .upd(upd), .clr(1'b0), .x(main_q), .low_st(pf_low)
  );

  bkup_hyst_cmp #(.W(W), .LO_MV(AUX_LO), .HI_MV(AUX_HI), .RST_LO(1'b0)) u_thr (
    .clk(clk), .rst(rst), .upd(upd), .clr(sel_nxt == SRC_BATT), .x(aux_q),
    .low_st(thr_low)
  );

  always_ff @(posedge clk) begin
    if (rst)      ce_hold <= 1'b1;
    else if (upd) ce_hold <= ce_q;
  end

  assign on_batt    = (sel == SRC_BATT);
  assign pwr_fail_n = ~pf_low;
  assign ce_out_n   = ce_hold | pf_low;
  assign thr_n      = ~thr_low;

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!on_batt && ce_out_n && !pwr_fail_n && thr_n));
  // R2: outputs move only on an update cycle
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable({on_batt, ce_out_n, pwr_fail_n, thr_n}));
  // R7: memory is write-protected during power fail
  a_r7_ce_protect: assert property (@(posedge clk) disable iff (rst)
    !pwr_fail_n |-> ce_out_n);
  // R9: detector silent while on battery
  a_r9_thr_off: assert property (@(posedge clk) disable iff (rst)
    on_batt |-> thr_n);
endmodule

// File: tb/tb_bkup_switch_ctl.sv
module tb_bkup_switch_ctl;
  localparam int CLK_PER = 10;
  localparam int W = 13;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_vld = 1'b0;
  logic [W-1:0] main_mv = '0, batt_mv = '0, aux_mv = '0;
  logic         ce_req_n = 1'b1;
  logic         on_batt, ce_out_n, pwr_fail_n, thr_n;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  bkup_switch_ctl dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld),
    .main_mv(main_mv), .batt_mv(batt_mv), .aux_mv(aux_mv), .ce_req_n(ce_req_n),
    .on_batt(on_batt), .ce_out_n(ce_out_n), .pwr_fail_n(pwr_fail_n), .thr_n(thr_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // drive one sample set and wait until the outputs have updated
  task automatic apply(input int m, input int b, input int a, input logic ce);
    @(negedge clk);
    main_mv = W'(m); batt_mv = W'(b); aux_mv = W'(a); ce_req_n = ce;
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 on_batt", on_batt, 1'b0);
    chk("R1 ce_out_n", ce_out_n, 1'b1);
    chk("R1 pwr_fail_n", pwr_fail_n, 1'b0);
    chk("R1 thr_n", thr_n, 1'b1);
  endtask

  task automatic t_pf_ce();
    apply(5000, 3000, 2000, 1'b0);
    chk("R6 pf high", pwr_fail_n, 1'b1);
    chk("R7 ce passes low", ce_out_n, 1'b0);
    apply(5000, 3000, 2000, 1'b1);
    chk("R7 ce passes high", ce_out_n, 1'b1);
    apply(4499, 3000, 2000, 1'b0);
    chk("R6 pf low at 4499", pwr_fail_n, 1'b0);
    chk("R7 ce blocked", ce_out_n, 1'b1);
    apply(4500, 3000, 2000, 1'b0);
    chk("R6 pf high at 4500", pwr_fail_n, 1'b1);
    chk("R7 ce passes at 4500", ce_out_n, 1'b0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    main_mv = W'(1000); aux_mv = W'(100); ce_req_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 pf held", pwr_fail_n, 1'b1);
    chk("R2 ce held", ce_out_n, 1'b0);
    chk("R2 src held", on_batt, 1'b0);
    chk("R2 thr held", thr_n, 1'b1);
  endtask

  task automatic t_switch();
    apply(2991, 3000, 2000, 1'b1);
    chk("R5 9 below stays main", on_batt, 1'b0);
    apply(2990, 3000, 2000, 1'b1);
    chk("R3 10 below to batt", on_batt, 1'b1);
    apply(3009, 3000, 2000, 1'b1);
    chk("R5 9 above stays batt", on_batt, 1'b1);
    apply(3010, 3000, 2000, 1'b1);
    chk("R4 10 above to main", on_batt, 1'b0);
  endtask

  task automatic t_thr();
    apply(5000, 3000, 1300, 1'b1);
    chk("R8 1300 inactive", thr_n, 1'b1);
    apply(5000, 3000, 1299, 1'b1);
    chk("R8 1299 active", thr_n, 1'b0);
    apply(5000, 3000, 1309, 1'b1);
    chk("R8 1309 holds", thr_n, 1'b0);
    apply(5000, 3000, 1310, 1'b1);
    chk("R8 1310 releases", thr_n, 1'b1);
    apply(5000, 3000, 1200, 1'b1);
    chk("R8 1200 active", thr_n, 1'b0);
    apply(2000, 3000, 1200, 1'b1);
    chk("R9 on batt", on_batt, 1'b1);
    chk("R9 thr off", thr_n, 1'b1);
    apply(5000, 3000, 1305, 1'b1);
    chk("R9 back on main", on_batt, 1'b0);
    chk("R9 state cleared", thr_n, 1'b1);
  endtask

  task automatic t_ovf();
    apply(8191, 8185, 2000, 1'b1);
    chk("R10 no wrap to batt", on_batt, 1'b0);
    apply(100, 8191, 2000, 1'b1);
    chk("R10 to batt", on_batt, 1'b1);
    apply(8191, 8191, 2000, 1'b1);
    chk("R10 no wrap to main", on_batt, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pf_ce();
    t_hold();
    t_switch();
    t_thr();
    t_ovf();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule